// File: doc/BRIEF.md
# Switchable-Resolution PWM Channel

This block produces one pulse-width-modulated waveform from a free-running counter and a duty comparator. The counter advances once per prescaler tick. The prescaler divides the core clock by 4, 8, 16 or 32. A control value chooses the counter width at run time. The counter is either 8 bits, wrapping after 255, or 5 bits, wrapping after 31. The 5-bit setting gives a period eight times shorter at the same prescale.

Software loads the control and duty values through a single-cycle write port. A new duty value waits in a pending register and becomes active only at the next counter wrap, so a period is never cut short or stretched. Writing the control value restarts the prescaler and the counter from zero. The output pin is shared with a general-purpose output and a select input picks which one drives it. The block raises no interrupt. Two copies give two independent channels.

Top module: `pwm_dual_res`

## Requirements
- R1: After reset the control value is 0 (8-bit mode, divide by 4), the active duty is 0 and the counter is 0, so with `pwm_en_i` high the pin is low.
- R2: Control bit 2 selects the resolution: 0 gives 8 bits and 1 gives 5 bits. Control bits 7:3 have no effect.
- R3: Control bits 1:0 form the divider code `c`. The counter advances once every 4<<c clocks, which is 4, 8, 16 or 32.
- R4: The counter wraps to 0 after 0xFF in 8-bit mode and after 0x1F in 5-bit mode. The period is therefore 256*div clocks or 32*div clocks.
- R5: The PWM output is high while the counter is below the active duty. It goes low when the counter equals the duty and stays low until the wrap. The high time per period is duty*div clocks, starting at the start of the period.
- R6: In 5-bit mode only duty bits 4:0 are compared, so a duty of 0x2A behaves like 0x0A.
- R7: A duty of 0 keeps the output low for the whole period. In 8-bit mode a duty of 0xFF gives a high time of 255 counts out of 256.
- R8: A duty written in mid-period does not change the current period. It takes effect from the next wrap.
- R9: A control write clears the prescaler and the counter. It also makes the pending duty active, so the first sample after the write edge is the start of a fresh period.
- R10: When `pwm_en_i` is 1 the pin carries the PWM output. When it is 0 the pin carries `gpio_i`.
- R11: A write happens on a clock edge with `wr_en_i` high. `wr_addr_i`=0 addresses the control value and `wr_addr_i`=1 addresses the duty value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = control, 1 = duty |
| wr_data_i | input | 8 | Write data |
| pwm_en_i | input | 1 | 1 = PWM drives the pin, 0 = GPIO drives it |
| gpio_i | input | 1 | General-purpose value for the shared pin |
| pin_o | output | 1 | Shared output pin |

## Verification
The bench goes after the duty extremes 0 and 0xFF. A comparator that used less-or-equal would show a sliver of high at duty 0 and a full-high period at 0xFF. In 5-bit mode the bench drives duty values with bit 5 set. A design that did not mask those bits would hold the pin high for the whole short period.

A duty write in mid-period must leave the running period's high count unchanged. A design without the pending register would produce a glitched period. Control writes with garbage in bits 7:3, and repeated control writes in mid-period, expose a wrong decode or a restart that misses the prescaler. Either fault shows up as a shifted first edge or a wrong period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_DUTY = 1'b1
  } pwm_addr_e;

  typedef struct packed {
    logic       res5;
    logic [1:0] div_code;
  } pwm_ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output pwm_ctrl_t         ctrl_o,
  output logic [DATA_W-1:0] duty_pend_o,
  output logic              restart_o
);
  pwm_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] duty_q;
  logic              wr_ctrl, wr_duty;

  assign wr_ctrl = wr_en_i && (pwm_addr_e'(wr_addr_i) == ADDR_CTRL);
  assign wr_duty = wr_en_i && (pwm_addr_e'(wr_addr_i) == ADDR_DUTY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      duty_q <= '0;
    end else begin
      // bits above 2 are dropped on purpose
      if (wr_ctrl) ctrl_q <= '{res5: wr_data_i[2], div_code: wr_data_i[1:0]};
      if (wr_duty) duty_q <= wr_data_i;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign duty_pend_o = duty_q;
  assign restart_o   = wr_ctrl;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int CODE_W   = 2,
  parameter int BASE_LOG = 2,
  localparam int PRE_W   = BASE_LOG + (1 << CODE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [PRE_W-1:0]  pre_o,
  output logic              tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  // limit = 2^(BASE_LOG+code) - 1
  assign limit  = {PRE_W{1'b1}} >> (PRE_W - BASE_LOG - int'(code_i));
  assign tick_o = (pre_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  assign pre_o = pre_q;
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 8,
  parameter int LOW_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic             res5_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] TOP_HI = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TOP_LO = {{(CNT_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top;

  assign top    = res5_i ? TOP_LO : TOP_HI;
  assign wrap_o = tick_i && (cnt_q == top);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W = 8,
  parameter int LOW_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             res5_i,
  input  logic [CNT_W-1:0] duty_pend_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] duty_act_o,
  output logic [CNT_W-1:0] duty_eff_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] act_q;

  // pending duty only becomes active on a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (load_i) act_q <= duty_pend_i;
  end

  assign duty_eff_o = res5_i ? {{(CNT_W-LOW_W){1'b0}}, act_q[LOW_W-1:0]} : act_q;
  assign pwm_o      = (cnt_i < duty_eff_o);
  assign duty_act_o = act_q;
endmodule

// File: rtl/pwm_dual_res.sv
module pwm_dual_res
  import pwm_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int LOW_W    = 5,
  parameter int CODE_W   = 2,
  parameter int BASE_LOG = 2,
  localparam int PRE_W   = BASE_LOG + (1 << CODE_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             pwm_en_i,
  input  logic             gpio_i,
  output logic             pin_o
);
  pwm_ctrl_t        ctrl;
  logic [CNT_W-1:0] duty_pend;
  logic             restart;
  logic [PRE_W-1:0] pre_q;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;
  logic [CNT_W-1:0] duty_act;
  logic [CNT_W-1:0] duty_eff;
  logic             pwm_raw;

  pwm_regs #(.DATA_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .duty_pend_o(duty_pend), .restart_o(restart)
  );

  pwm_prescaler #(.CODE_W(CODE_W), .BASE_LOG(BASE_LOG)) i_pre (
    .clk_i, .rst_ni, .clear_i(restart), .code_i(ctrl.div_code),
    .pre_o(pre_q), .tick_o(tick)
  );

  pwm_counter #(.CNT_W(CNT_W), .LOW_W(LOW_W)) i_cnt (
    .clk_i, .rst_ni, .clear_i(restart), .tick_i(tick), .res5_i(ctrl.res5),
    .cnt_o(cnt_q), .wrap_o(wrap)
  );

  pwm_compare #(.CNT_W(CNT_W), .LOW_W(LOW_W)) i_cmp (
    .clk_i, .rst_ni, .load_i(wrap || restart), .res5_i(ctrl.res5),
    .duty_pend_i(duty_pend), .cnt_i(cnt_q),
    .duty_act_o(duty_act), .duty_eff_o(duty_eff), .pwm_o(pwm_raw)
  );

  assign pin_o = pwm_en_i ? pwm_raw : gpio_i;
endmodule

// File: rtl/pwm_dual_res_chk.sv
module pwm_dual_res_chk #(
  parameter int CNT_W = 8,
  parameter int LOW_W = 5,
  parameter int PRE_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             wr_addr_i,
  input logic             res5_i,
  input logic [PRE_W-1:0] pre_i,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] duty_act_i,
  input logic [CNT_W-1:0] duty_eff_i,
  input logic             pwm_i
);
  localparam logic [CNT_W-1:0] LO_TOP = CNT_W'((1 << LOW_W) - 1);
  localparam logic [CNT_W-1:0] HI_TOP = {CNT_W{1'b1}};

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res5_i && !$past(wr_en_i)) |-> cnt_i <= LO_TOP);

  // R4
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == (res5_i ? LO_TOP : HI_TOP)) |=> cnt_i == '0);

  // R3
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  // R5
  fall_at_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_i) |-> cnt_i == duty_eff_i);

  // R8
  duty_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(duty_act_i) |-> cnt_i == '0);

  // R9
  restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_addr_i) |=> (cnt_i == '0 && pre_i == '0));
endmodule

bind pwm_dual_res pwm_dual_res_chk #(.CNT_W(CNT_W), .LOW_W(LOW_W), .PRE_W(PRE_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .res5_i(ctrl.res5), .pre_i(pre_q), .tick_i(tick), .cnt_i(cnt_q),
  .duty_act_i(duty_act), .duty_eff_i(duty_eff), .pwm_i(pwm_raw)
);

// File: tb/test_pwm_dual_res.sv
module test_pwm_dual_res;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       pwm_en = 1'b1;
  logic       gpio = 1'b0;
  logic       pin;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_dual_res i_pwm_dual_res (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_en_i(pwm_en), .gpio_i(gpio), .pin_o(pin)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(logic addr, logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // writes duty then control, measures one period plus one sample
  task automatic run_period(logic [7:0] ctrl, logic [7:0] duty, string req);
    int div, per, eff, highs, first_low, last;
    div = 4 << ctrl[1:0];
    per = (ctrl[2] ? 32 : 256) * div;
    eff = ctrl[2] ? int'(duty[4:0]) : int'(duty);
    write_reg(1'b1, duty);
    write_reg(1'b0, ctrl);
    highs = 0; first_low = -1; last = 0;
    for (int j = 0; j <= per; j++) begin
      if (j < per) begin
        if (pin) highs++;
        else if (first_low < 0) first_low = j;
      end else last = int'(pin);
      @(negedge clk);
    end
    if (first_low < 0) first_low = per;
    check({req, " high count"}, highs, eff * div);
    check({req, " first low"}, first_low, eff * div);
    check({req, " R4 next period start"}, last, (eff > 0) ? 1 : 0);
  endtask

  task automatic t_reset;
    pwm_en = 1'b1; gpio = 1'b1;
    #1;
    check("R1 reset pin low", int'(pin), 0);
    repeat (20) @(negedge clk);
    check("R1 stays low (duty 0)", int'(pin), 0);
  endtask

  task automatic t_gpio;
    pwm_en = 1'b0;
    gpio = 1'b1; #1;
    check("R10 gpio high", int'(pin), 1);
    gpio = 1'b0; #1;
    check("R10 gpio low", int'(pin), 0);
    pwm_en = 1'b1; gpio = 1'b1;
    write_reg(1'b1, 8'h00);
    write_reg(1'b0, 8'h00);
    check("R10 pwm selected", int'(pin), 0);
    gpio = 1'b0;
  endtask

  task automatic t_duty_update;
    int highs0, highs1;
    write_reg(1'b1, 8'h10);
    write_reg(1'b0, 8'h00);
    highs0 = 0; highs1 = 0;
    for (int j = 0; j < 2048; j++) begin
      if (pin) begin
        if (j < 1024) highs0++;
        else highs1++;
      end
      if (j == 5) begin wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h30; end
      if (j == 6) wr_en = 1'b0;
      @(negedge clk);
    end
    check("R8 current period unchanged", highs0, 16 * 4);
    check("R8 next period new duty", highs1, 48 * 4);
  endtask

  task automatic t_restart;
    write_reg(1'b1, 8'h20);
    write_reg(1'b0, 8'h00);
    repeat (300) @(negedge clk);
    check("R9 low before restart", int'(pin), 0);
    run_period(8'h00, 8'h20, "R9 R11 restart mid-period");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_period(8'h00, 8'h40, "R5 R11 8-bit div4");
    run_period(8'h00, 8'h00, "R7 duty zero");
    run_period(8'h00, 8'hFF, "R7 duty max");
    run_period(8'h01, 8'h03, "R3 div8");
    run_period(8'h04, 8'h0A, "R2 5-bit");
    run_period(8'h04, 8'h2A, "R6 masked duty");
    run_period(8'h04, 8'h20, "R6 masked to zero");
    run_period(8'h04, 8'h1F, "R4 5-bit duty top");
    run_period(8'h07, 8'h05, "R3 5-bit div32");
    run_period(8'hF9, 8'h02, "R2 upper bits ignored");
    t_duty_update();
    t_restart();
    t_gpio();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule